// File: doc/BRIEF.md
# Expansion-Bus Hold and Flush Responder

This block sits on the bridge side of an expansion bus that the bridge owns by default. An external arbiter asks the bridge to step aside by raising a hold request. The bridge grants that with a hold acknowledge one clock later, unless a local expansion-bus cycle is still running. When the arbiter withdraws hold, the bridge drops the acknowledge and takes the bus back.

A shared, bidirectional flush line coordinates buffer draining. The arbiter asserts the line to ask the bridge to empty its posted-write buffers. When the bridge samples the line asserted, it takes over driving it asserted and tells its buffer logic to drain. It keeps the line asserted until every buffer reports empty. It then drives the line negated for a single clock and releases it. The line is modelled as a sampled level, a drive enable and a drive value.

While another master owns the expansion bus, a primary-bus access aimed at that bus is answered with a retry. The bridge also raises a bus request to win the bus back. The buffers and the retry protocol themselves are outside this block and appear only as status inputs and outputs.

Top module: `hold_flush_responder`

## Requirements
- R1: Synchronous reset leaves the flush line undriven (drive enable 0), hold acknowledge 0, bridge owner 1, bus request 0, retry 0 and drain request 0, whatever the inputs.
- R2: With hold acknowledge low, a hold request sampled high while the local-busy input is low raises hold acknowledge at the next clock edge. While local-busy is high, hold acknowledge stays low.
- R3: With hold acknowledge high, a hold request sampled low drops hold acknowledge at the next clock edge, and bridge owner returns to 1. Bridge owner is always the inverse of hold acknowledge.
- R4: When the responder is not driving the flush line and samples it high (1 = asserted), it drives the line from the next clock with enable 1 and value 1, and raises the drain request.
- R5: While driving the line asserted, the responder keeps enable 1, value 1 and the drain request high for as long as any bit of the buffer-empty vector is 0. Bit i = 1 means buffer i is empty.
- R6: After a clock edge in the asserted-drive phase with every buffer-empty bit at 1, the responder drives enable 1 and value 0 for exactly one clock, with the drain request low, and then sets enable to 0.
- R7: A primary-bus request while hold acknowledge is high raises retry in the same cycle. If hold is still requested at the next edge, bus request is set and stays set while hold acknowledge remains high.
- R8: A primary-bus request while the bridge owns the bus gives no retry and leaves bus request at 0.
- R9: Bus request is 0 whenever hold acknowledge is 0, and it clears at the same edge where hold acknowledge falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req_i | input | 1 | Arbiter asks the bridge to release the expansion bus |
| local_busy_i | input | 1 | Local expansion-bus cycle in progress |
| pri_req_i | input | 1 | Primary-bus master targets the expansion bus |
| flush_line_i | input | 1 | Sampled level of the shared flush line (1 = asserted) |
| buf_empty_i | input | NUM_BUFS | Per-buffer empty flags |
| hold_ack_o | output | 1 | Hold acknowledge to the arbiter |
| bridge_owner_o | output | 1 | Bridge currently owns the expansion bus |
| bus_req_o | output | 1 | Bridge request for the expansion bus |
| retry_o | output | 1 | Retry the current primary-bus access |
| drain_o | output | 1 | Request to empty the buffers |
| flush_oe_o | output | 1 | Drive enable for the flush line |
| flush_val_o | output | 1 | Value driven on the flush line when enabled |

## Verification
The bench builds the responder with three buffers. This lets partial patterns such as one or two empty flags be shown to hold the line asserted, while only the full set releases it. The single buffer count still covers the reduction over the whole vector. The table also interleaves hold grants with a flush, which shows the ownership and flush sequences running independently. Directed runs add a reset in the middle of a grant and a drain, and an exact count of the negation pulse length.

// File: rtl/hfr_pkg.sv
package hfr_pkg;

    typedef enum logic {
        OWN_BRIDGE = 1'b0,
        OWN_REMOTE = 1'b1
    } own_state_e;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_DRAIN = 2'd1,
        FL_DONE  = 2'd2
    } flush_state_e;

    typedef struct packed {
        logic oe;
        logic val;
    } line_drive_t;

    localparam line_drive_t DRIVE_OFF = '{oe: 1'b0, val: 1'b0};
    localparam line_drive_t DRIVE_HI  = '{oe: 1'b1, val: 1'b1};
    localparam line_drive_t DRIVE_LO  = '{oe: 1'b1, val: 1'b0};

    function automatic logic all_set(input logic [31:0] flags, input int unsigned n);
        logic r;
        r = 1'b1;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < n && !flags[i]) r = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/hfr_own_fsm.sv
module hfr_own_fsm
    import hfr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold_req_i,
    input  logic local_busy_i,
    output logic hold_ack_o
);

    own_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_BRIDGE: if (hold_req_i && !local_busy_i) state_d = OWN_REMOTE;
            OWN_REMOTE: if (!hold_req_i)                 state_d = OWN_BRIDGE;
            default:                                     state_d = OWN_BRIDGE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OWN_BRIDGE;
        else     state_q <= state_d;
    end

    assign hold_ack_o = (state_q == OWN_REMOTE);

    AST_ACK_ON_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!hold_ack_o && hold_req_i && !local_busy_i) |=> hold_ack_o); // R2
    AST_BUSY_BLOCKS_ACK: assert property (@(posedge clk) disable iff (rst)
        (!hold_ack_o && local_busy_i) |=> !hold_ack_o); // R2
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (hold_ack_o && !hold_req_i) |=> !hold_ack_o); // R3

endmodule

// File: rtl/hfr_flush_fsm.sv
module hfr_flush_fsm
    import hfr_pkg::*;
#(
    parameter int unsigned NUM_BUFS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush_line_i,
    input  logic [NUM_BUFS-1:0] buf_empty_i,
    output logic                drain_o,
    output line_drive_t         drive_o
);

    localparam int unsigned PADW = 32;

    flush_state_e state_q, state_d;
    logic         empty_all;
    logic [PADW-1:0] flags_pad;

    assign flags_pad = PADW'(buf_empty_i);
    assign empty_all = all_set(flags_pad, NUM_BUFS);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  if (flush_line_i) state_d = FL_DRAIN;
            FL_DRAIN: if (empty_all)    state_d = FL_DONE;
            FL_DONE:                    state_d = FL_IDLE;
            default:                    state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FL_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FL_DRAIN: drive_o = DRIVE_HI;
            FL_DONE:  drive_o = DRIVE_LO;
            default:  drive_o = DRIVE_OFF;
        endcase
    end

    assign drain_o = (state_q == FL_DRAIN);

    AST_TAKE_LINE: assert property (@(posedge clk) disable iff (rst)
        (!drive_o.oe && flush_line_i) |=> (drive_o.oe && drive_o.val && drain_o)); // R4
    AST_HOLD_UNTIL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (drive_o.oe && drive_o.val && !(&buf_empty_i)) |=> (drive_o.oe && drive_o.val)); // R5
    AST_PULSE_AFTER_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (drive_o.oe && drive_o.val && (&buf_empty_i)) |=> (drive_o.oe && !drive_o.val)); // R6
    AST_PULSE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (drive_o.oe && !drive_o.val) |=> !drive_o.oe); // R6

endmodule

// File: rtl/hfr_retry.sv
module hfr_retry (
    input  logic clk,
    input  logic rst,
    input  logic hold_ack_i,
    input  logic hold_req_i,
    input  logic pri_req_i,
    output logic retry_o,
    output logic bus_req_o
);

    logic breq_q, breq_d;

    // request persists while the grant stays out; cleared as ownership returns
    assign breq_d  = hold_ack_i && hold_req_i && (breq_q || pri_req_i);
    assign retry_o = hold_ack_i && pri_req_i;

    always_ff @(posedge clk) begin
        if (rst) breq_q <= 1'b0;
        else     breq_q <= breq_d;
    end

    assign bus_req_o = breq_q;

    AST_BREQ_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        bus_req_o |-> hold_ack_i); // R9
    AST_RETRY_RAISES_BREQ: assert property (@(posedge clk) disable iff (rst)
        (retry_o && hold_req_i) |=> bus_req_o); // R7
    AST_OWNER_NO_RETRY: assert property (@(posedge clk) disable iff (rst)
        !hold_ack_i |-> !retry_o); // R8

endmodule

// File: rtl/hold_flush_responder.sv
module hold_flush_responder
    import hfr_pkg::*;
#(
    parameter int unsigned NUM_BUFS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold_req_i,
    input  logic                local_busy_i,
    input  logic                pri_req_i,
    input  logic                flush_line_i,
    input  logic [NUM_BUFS-1:0] buf_empty_i,
    output logic                hold_ack_o,
    output logic                bridge_owner_o,
    output logic                bus_req_o,
    output logic                retry_o,
    output logic                drain_o,
    output logic                flush_oe_o,
    output logic                flush_val_o
);

    logic        ack;
    line_drive_t drv;

    hfr_own_fsm u_own (
        .clk          (clk),
        .rst          (rst),
        .hold_req_i   (hold_req_i),
        .local_busy_i (local_busy_i),
        .hold_ack_o   (ack)
    );

    hfr_flush_fsm #(.NUM_BUFS(NUM_BUFS)) u_flush (
        .clk          (clk),
        .rst          (rst),
        .flush_line_i (flush_line_i),
        .buf_empty_i  (buf_empty_i),
        .drain_o      (drain_o),
        .drive_o      (drv)
    );

    hfr_retry u_retry (
        .clk        (clk),
        .rst        (rst),
        .hold_ack_i (ack),
        .hold_req_i (hold_req_i),
        .pri_req_i  (pri_req_i),
        .retry_o    (retry_o),
        .bus_req_o  (bus_req_o)
    );

    assign hold_ack_o     = ack;
    assign bridge_owner_o = !ack;
    assign flush_oe_o     = drv.oe;
    assign flush_val_o    = drv.val;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!flush_oe_o && !hold_ack_o && !bus_req_o && !drain_o)); // R1

endmodule

// File: tb/tb_hold_flush_responder.sv
`timescale 1ns/1ps
module tb_hold_flush_responder;

    localparam int NB = 3;
    localparam int NV = 18;

    logic clk = 1'b0;
    logic rst;
    logic hold_req, local_busy, pri_req, flush_line;
    logic [NB-1:0] buf_empty;
    logic hold_ack, bridge_owner, bus_req, retry, drain, flush_oe, flush_val;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hold_flush_responder #(.NUM_BUFS(NB)) dut (
        .clk(clk), .rst(rst),
        .hold_req_i(hold_req), .local_busy_i(local_busy), .pri_req_i(pri_req),
        .flush_line_i(flush_line), .buf_empty_i(buf_empty),
        .hold_ack_o(hold_ack), .bridge_owner_o(bridge_owner), .bus_req_o(bus_req),
        .retry_o(retry), .drain_o(drain), .flush_oe_o(flush_oe), .flush_val_o(flush_val)
    );

    // [16:13] req | hold busy pri flush | empty[2:0] | ack breq retry oe val drain
    localparam logic [16:0] VEC [NV] = '{
        {4'd1, 4'b0000, 3'b111, 6'b000000},  // R1 idle after reset
        {4'd8, 4'b0010, 3'b111, 6'b000000},  // R8 primary request while owner
        {4'd2, 4'b1100, 3'b111, 6'b000000},  // R2 busy blocks grant
        {4'd2, 4'b1100, 3'b111, 6'b000000},  // R2
        {4'd2, 4'b1000, 3'b111, 6'b100000},  // R2 grant
        {4'd7, 4'b1010, 3'b111, 6'b111000},  // R7 retry and request
        {4'd7, 4'b1000, 3'b111, 6'b110000},  // R7 request held
        {4'd9, 4'b0000, 3'b111, 6'b000000},  // R9 / R3 release
        {4'd8, 4'b0010, 3'b111, 6'b000000},  // R8
        {4'd4, 4'b0001, 3'b000, 6'b000111},  // R4 take line
        {4'd5, 4'b0001, 3'b010, 6'b000111},  // R5 partial
        {4'd5, 4'b0001, 3'b110, 6'b000111},  // R5 partial
        {4'd6, 4'b0001, 3'b111, 6'b000100},  // R6 pulse
        {4'd6, 4'b0000, 3'b111, 6'b000000},  // R6 release
        {4'd6, 4'b0000, 3'b111, 6'b000000},  // R6
        {4'd4, 4'b1001, 3'b111, 6'b100111},  // R4 with grant
        {4'd6, 4'b1001, 3'b111, 6'b100100},  // R6 with grant
        {4'd3, 4'b0000, 3'b111, 6'b000000}   // R3
    };

    function automatic logic [6:0] outs();
        return {hold_ack, bus_req, retry, flush_oe, flush_val, drain, bridge_owner};
    endfunction

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (ack breq retry oe val drain owner)", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] ctl, input logic [NB-1:0] emp);
        @(negedge clk);
        {hold_req, local_busy, pri_req, flush_line} = ctl;
        buf_empty = emp;
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        rst = 1'b1;
        hold_req = 1'b1; local_busy = 1'b0; pri_req = 1'b1; flush_line = 1'b1;
        buf_empty = '0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset", outs(), 7'b0000001);
        drive(4'b0000, '1);
        rst = 1'b0;
        settle();

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][12:9], VEC[i][8:6]);
            settle();
            chk($sformatf("R%0d vector %0d", VEC[i][16:13], i), outs(),
                {VEC[i][5:0], !VEC[i][5]});
        end

        // R6: negation pulse lasts exactly one clock
        begin
            int lo_cnt;
            lo_cnt = 0;
            drive(4'b0001, 3'b000);
            settle();
            drive(4'b0000, 3'b001);
            settle();
            chk("R5 still driving", outs(), 7'b0001111);
            drive(4'b0000, 3'b111);
            for (int k = 0; k < 5; k++) begin
                settle();
                if (flush_oe && !flush_val) lo_cnt++;
            end
            chk("R6 pulse length", {6'd0, lo_cnt == 1}, 7'd1);
            chk("R6 released", outs(), 7'b0000001);
        end

        // R1: reset in mid grant and mid drain
        drive(4'b1001, 3'b000);
        settle();
        drive(4'b1011, 3'b000);
        settle();
        chk("R7 retry pre-reset", outs(), 7'b1111110);
        @(negedge clk);
        rst = 1'b1;
        settle();
        chk("R1 mid-run reset", {outs()[6:5], 1'b0, outs()[3:0]}, 7'b0000001);
        drive(4'b0000, '1);
        rst = 1'b0;
        settle();
        chk("R1 after reset", outs(), 7'b0000001);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule